// File: doc/BRIEF.md
# Packed YUV Line Unpacker with Mirroring

This block takes packed 4:2:2 pixel words, each 32 bits wide and holding two pixels that share one chroma pair. It turns them into a stream of single pixels with separate luma, blue-difference and red-difference bytes, ready for a downstream scaler. Each word can use one of four byte orders. A start pulse captures the mode, the line width in words and the line count. The block then fetches one line at a time into a small line store and emits that line's pixels. While it works it raises busy, and at the end of the frame it sets a sticky done flag.

Mirroring is controlled separately for the source side and the destination side. On each axis the two controls combine by exclusive-or, so setting both leaves the image unchanged on that axis. For a horizontal mirror the block reads the line store from its far end and swaps the two luma samples of each word, while the chroma stays with its pair. For a vertical mirror the block asks for lines from last to first. It does this through its line-index output, and the memory side uses that output to choose which line to deliver.

Top module: `yuv_mirror_unpack`

## Requirements
- R1: After reset, busy, done, in_ready and pix_valid are all 0.
- R2: A start pulse while idle captures cfg_mode, cfg_words and cfg_lines, sets busy and clears done one cycle later. A start pulse while busy is ignored, and so is any change to the config inputs.
- R3: Byte 0 is in_data[7:0] and byte 3 is in_data[31:24]. Format 0 (cfg_mode[5:4]) holds bytes Y0,Cb,Y1,Cr. Format 1 holds Y0,Cr,Y1,Cb. Format 2 holds Cb,Y0,Cr,Y1. Format 3 holds Cr,Y0,Cb,Y1.
- R4: With no horizontal mirror, each word gives two pixels in line order: first Y0, then Y1. Both pixels carry the word's Cb and Cr.
- R5: With horizontal mirror, the words of a line come out last word first. Within each word Y1 comes out before Y0, and both pixels carry that word's chroma.
- R6: line_idx names the source line being fetched. It counts 0 up to lines-1, or lines-1 down to 0 when vertical mirror is in effect. The pixels of each line come out in that same order.
- R7: The horizontal mirror in effect is cfg_mode[0] XOR cfg_mode[2]. The vertical mirror in effect is cfg_mode[1] XOR cfg_mode[3].
- R8: in_ready is high only while a line is being fetched, and it stays high until cfg_words words have been accepted. Pixels of that line are then offered, and pix_valid is never high at the same time as in_ready.
- R9: While pix_valid is high and pix_ready is low, the pixel outputs and pix_last hold their values.
- R10: pix_last marks the final pixel of the frame. One cycle after that pixel's handshake, busy is 0 and done is 1. done stays 1 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (idle only) |
| cfg_mode | input | 6 | Mirror bits [3:0], byte-order format [5:4] |
| cfg_words | input | WW | Words per line, 1..MAXW |
| cfg_lines | input | LW | Lines per frame, at least 1 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when valid |
| in_data | input | 32 | Packed two-pixel word |
| line_idx | output | LW | Source line currently fetched |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts pixel |
| pix_y | output | 8 | Luma |
| pix_cb | output | 8 | Blue-difference chroma |
| pix_cr | output | 8 | Red-difference chroma |
| pix_last | output | 1 | Final pixel of frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky frame-complete flag |

## Verification
Busy and done respond one cycle after the start edge, and the bench samples them at the following falling edge. The pixel outputs and line_idx are driven straight from registered state and the line store. They are therefore valid in the same cycle as a handshake, and the bench evaluates each handshake shortly after the falling edge, once it has driven that cycle's inputs. The end-of-frame flags are checked at the first falling edge after the pixel marked last has been handed off. They are checked again two cycles later to confirm that done is sticky.

// File: rtl/yuv_mirror_unpack.sv
module yuv_mirror_unpack #(
  parameter int MAXW = 16,
  parameter int LW   = 8,
  localparam int WW  = $clog2(MAXW + 1),
  localparam int AW  = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    cfg_mode,
  input  logic [WW-1:0] cfg_words,
  input  logic [LW-1:0] cfg_lines,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  output logic [LW-1:0] line_idx,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [7:0]    pix_y,
  output logic [7:0]    pix_cb,
  output logic [7:0]    pix_cr,
  output logic          pix_last,
  output logic          busy,
  output logic          done
);
  typedef enum logic [1:0] {IDLE, FILL, DRAIN} st_t;

  st_t           st;
  logic [5:0]    mode_q;
  logic [WW-1:0] words_q, wcnt;
  logic [LW-1:0] lines_q, lcnt;
  logic          half, done_q;
  logic [31:0]   lbuf [MAXW];

  wire hm     = mode_q[0] ^ mode_q[2];
  wire vm     = mode_q[1] ^ mode_q[3];
  wire last_w = (wcnt == words_q - WW'(1));
  wire last_l = (lcnt == lines_q - LW'(1));
  wire in_hs  = in_valid && in_ready;
  wire px_hs  = pix_valid && pix_ready;

  wire [WW-1:0] rd_idx = hm ? (words_q - WW'(1) - wcnt) : wcnt;
  wire [31:0]   word   = lbuf[rd_idx[AW-1:0]];

  logic [7:0] y0, y1, cb, cr;
  always_comb begin
    unique case (mode_q[5:4])
      2'd0: {cr, y1, cb, y0} = word;
      2'd1: {cb, y1, cr, y0} = word;
      2'd2: {y1, cr, y0, cb} = word;
      default: {y1, cb, y0, cr} = word;
    endcase
  end

  assign in_ready  = (st == FILL);
  assign pix_valid = (st == DRAIN);
  assign pix_y     = (half ^ hm) ? y1 : y0;
  assign pix_cb    = cb;
  assign pix_cr    = cr;
  assign pix_last  = pix_valid && half && last_w && last_l;
  assign line_idx  = vm ? (lines_q - LW'(1) - lcnt) : lcnt;
  assign busy      = (st != IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (in_hs) lbuf[wcnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      mode_q  <= '0;
      words_q <= '0;
      lines_q <= '0;
      wcnt    <= '0;
      lcnt    <= '0;
      half    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (st)
        IDLE: if (start) begin
          mode_q  <= cfg_mode;
          words_q <= cfg_words;
          lines_q <= cfg_lines;
          wcnt    <= '0;
          lcnt    <= '0;
          half    <= 1'b0;
          done_q  <= 1'b0;
          st      <= FILL;
        end
        FILL: if (in_hs) begin
          if (last_w) begin
            wcnt <= '0;
            st   <= DRAIN;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: if (px_hs) begin
          half <= ~half;
          if (half) begin
            if (last_w) begin
              wcnt <= '0;
              if (last_l) begin
                st     <= IDLE;
                done_q <= 1'b1;
              end else begin
                lcnt <= lcnt + LW'(1);
                st   <= FILL;
              end
            end else begin
              wcnt <= wcnt + WW'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

module yuv_mirror_unpack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_ready,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic [7:0] pix_y,
  input logic [7:0] pix_cb,
  input logic [7:0] pix_cr,
  input logic       pix_last,
  input logic       busy,
  input logic       done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !pix_valid));

  assert_phase_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && pix_valid));

  assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_y) && $stable(pix_cb)
                                   && $stable(pix_cr) && $stable(pix_last)));

  assert_frame_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && pix_last) |=> (!busy && done));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pix_valid && pix_ready && pix_last));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
endmodule

bind yuv_mirror_unpack yuv_mirror_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_y(pix_y),
  .pix_cb(pix_cb), .pix_cr(pix_cr), .pix_last(pix_last),
  .busy(busy), .done(done)
);

// File: tb/tb_yuv_mirror_unpack.sv
module tb_yuv_mirror_unpack;
  localparam int MAXW = 16;
  localparam int LW   = 8;
  localparam int WW   = $clog2(MAXW + 1);

  logic          clk = 0, rst_n = 0, start = 0;
  logic [5:0]    cfg_mode = '0;
  logic [WW-1:0] cfg_words = '0;
  logic [LW-1:0] cfg_lines = '0;
  logic          in_valid = 0, pix_ready = 0;
  logic [31:0]   in_data = '0;
  logic          in_ready, pix_valid, pix_last, busy, done;
  logic [LW-1:0] line_idx;
  logic [7:0]    pix_y, pix_cb, pix_cr;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  yuv_mirror_unpack #(.MAXW(MAXW), .LW(LW)) dut (.*);

  function automatic logic [7:0] ly(int l, int w); return 8'((l * 40 + w * 2) & 255); endfunction
  function automatic logic [7:0] lu(int l, int w); return 8'(8'h80 + l * 16 + w); endfunction
  function automatic logic [7:0] lv(int l, int w); return 8'(8'hC0 + l * 16 + w); endfunction

  function automatic logic [31:0] pack(int fmt, int l, int w);
    logic [7:0] a, b, u, v;
    a = ly(l, w); b = a + 8'd1; u = lu(l, w); v = lv(l, w);
    case (fmt)
      0: return {v, b, u, a};
      1: return {u, b, v, a};
      2: return {b, v, a, u};
      default: return {b, u, a, v};
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int m, int W, int L);
    int hm, vm, fmt, N, pc, wc, fl, e, p, sl, sp, w, sel, held;
    logic [7:0] hy, hb, hr; logic hl;
    logic [7:0] ey, eb, er;
    hm = (m & 1) ^ ((m >> 2) & 1);
    vm = ((m >> 1) & 1) ^ ((m >> 3) & 1);
    fmt = (m >> 4) & 3;
    @(negedge clk);
    cfg_mode = 6'(m); cfg_words = WW'(W); cfg_lines = LW'(L); start = 1;
    @(negedge clk);
    start = 0;
    #1;
    chk(busy && !done, "R2", "busy/done after start", {busy, done}, 2'b10);
    N = 2 * W * L; pc = 0; wc = 0; fl = 0; held = 0;
    while (pc < N) begin
      cyc++;
      start = (pc == N / 2) && (wc == 0);
      if (start) cfg_mode = ~6'(m);
      in_valid  = (cyc % 4) != 1;
      pix_ready = (cyc % 3) != 2;
      in_data   = pack(fmt, vm ? (L - 1 - fl) : fl, wc);
      #1;
      if (held) begin
        chk(pix_valid && pix_y == hy && pix_cb == hb && pix_cr == hr && pix_last == hl,
            "R9", "held pixel", {pix_y, pix_cb, pix_cr}, {hy, hb, hr});
        held = 0;
      end
      if (pix_valid && !pix_ready) begin
        held = 1; hy = pix_y; hb = pix_cb; hr = pix_cr; hl = pix_last;
      end
      if (pix_valid && pix_ready) begin
        e = pc / (2 * W); p = pc % (2 * W);
        sl = vm ? (L - 1 - e) : e;
        sp = hm ? (2 * W - 1 - p) : p;
        w = sp / 2; sel = sp % 2;
        ey = ly(sl, w) + 8'(sel); eb = lu(sl, w); er = lv(sl, w);
        chk({pix_y, pix_cb, pix_cr} == {ey, eb, er},
            hm ? "R5/R7" : "R3/R4", "pixel", {pix_y, pix_cb, pix_cr}, {ey, eb, er});
        chk(pix_last == (pc == N - 1), "R10", "pix_last", pix_last, pc == N - 1);
        pc++;
      end
      if (in_valid && in_ready) begin
        chk(line_idx == LW'(vm ? (L - 1 - fl) : fl), "R6", "line_idx",
            line_idx, vm ? (L - 1 - fl) : fl);
        chk(!pix_valid, "R8", "pix_valid during fetch", pix_valid, 0);
        wc++;
        if (wc == W) begin wc = 0; fl++; end
      end
      @(negedge clk);
      cfg_mode = 6'(m);
    end
    start = 0; in_valid = 0;
    #1;
    chk(!busy && done, "R10", "end flags", {busy, done}, 2'b01);
    repeat (2) @(negedge clk);
    #1;
    chk(done && !busy, "R10", "done sticky", {busy, done}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !in_ready && !pix_valid, "R1", "reset outputs",
        {busy, done, in_ready, pix_valid}, 0);
    rst_n = 1;
    for (int m = 0; m < 64; m++)
      for (int wi = 0; wi < 3; wi++)
        for (int li = 0; li < 2; li++)
          run_frame(m, (wi == 0) ? 1 : (wi == 1) ? 3 : MAXW, (li == 0) ? 1 : 3);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule